// File: doc/BRIEF.md
# Memory-Mode Address Decoder for an 8051-Class Bus

This block turns the address and strobes of an 8051-class microcontroller into chip selects for the memories and peripherals around it. The controller fetches code with its own strobe and reaches data with separate read and write strobes. The targets are a flash, a banked data RAM, a code RAM, a small common RAM, a dual-port RAM, a semaphore block and two peripheral controllers.

The mapping depends on a two-bit architecture mode. In loader mode and in application mode, code comes from flash. Harvard mode fetches code from a dedicated code RAM. Von-Neumann mode uses one RAM for both code and data. In every mode, the top 256 bytes are one common RAM that both code fetches and data accesses can reach. The I/O regions (dual-port RAM, semaphores, peripherals) answer only to data accesses. Application mode also lets software pick which half of the data RAM is visible: a write into one of two 256-byte trigger windows latches a bank bit.

Top module: `xmd_decoder`

## Requirements
- R1: Any access (code fetch, read or write) to FF00h–FFFFh asserts only `sel[3]` (common RAM), in all four modes.
- R2: A data access to F400h–F7FFh asserts `sel[6]` and one to F800h–FBFFh asserts `sel[7]` in application, Harvard and von-Neumann modes; in loader mode the same accesses assert no select.
- R3: In every mode, a data access to E000h–EFFFh asserts `sel[4]` (dual-port RAM). A data access to F000h–F3FFh asserts `sel[5]` (semaphores), and `sema_idx` then equals address bits 2:0. `sema_idx` is 0 whenever `sel[5]` is low.
- R4: In loader mode (`mode`=0) and application mode (`mode`=1), a code fetch below FF00h asserts `sel[0]` (flash).
- R5: In Harvard mode (`mode`=2), a code fetch below FF00h asserts `sel[2]` (code RAM), and a data access below E000h asserts `sel[1]` (data RAM).
- R6: In von-Neumann mode (`mode`=3), code fetches and data accesses below E000h both assert `sel[1]`. A code fetch in E000h–FEFFh asserts no select.
- R7: In loader and application modes, a data access below E000h asserts `sel[1]`.
- R8: `ram_bank` is 0 after reset. In application mode, a write to FC00h–FCFFh sets it to 0 and a write to FD00h–FDFFh sets it to 1, starting at the next clock edge. Writes to these windows in other modes, and reads anywhere, leave it unchanged.
- R9: At most one select is active at a time. With no strobe active, `sel` is 0. A data access to FC00h–FEFFh asserts none. When `code_fetch` is high it takes priority over the read and write strobes.
- R10: `sel` and `sema_idx` follow the inputs combinationally, within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the bank register |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 16 | Bus address |
| code_fetch | input | 1 | Code-fetch strobe, active high |
| rd_strobe | input | 1 | Data read strobe, active high |
| wr_strobe | input | 1 | Data write strobe, active high |
| mode | input | 2 | 0 loader, 1 application, 2 Harvard, 3 von-Neumann |
| sel | output | 8 | One-hot selects: 0 flash, 1 data RAM, 2 code RAM, 3 common RAM, 4 dual-port RAM, 5 semaphores, 6 peripheral 1, 7 peripheral 2 |
| ram_bank | output | 1 | Latched data-RAM bank |
| sema_idx | output | 3 | Semaphore number for the current access |

## Verification
The assertions assume that the mode stays stable around each access. They also assume that address and strobes are settled at every clock edge, so sampling the selects there is meaningful. Read and write may be raised together, and the priority rule still yields at most one select. The stimulus changes inputs only at the falling edge and checks before the next rising edge. Each access holds the mode constant and raises one strobe at a time, apart from the cases that test strobe priority. Bank writes are held for exactly one rising edge so the latch point is unambiguous.

// File: rtl/xmd_pkg.sv
// Shared definitions for the memory-mode decoder: modes, select positions
// and the address regions. Assumes a 16-bit bus address.
package xmd_pkg;

    localparam int ADDR_W = 16;
    localparam int NUM_SEL = 8;
    localparam int SEMA_W = 3;

    typedef enum logic [1:0] {
        MODE_LOADER  = 2'd0,
        MODE_APP     = 2'd1,
        MODE_HARVARD = 2'd2,
        MODE_VONN    = 2'd3
    } mem_mode_e;

    // Select bit positions
    localparam int SEL_FLASH  = 0;
    localparam int SEL_DRAM   = 1;
    localparam int SEL_CRAM   = 2;
    localparam int SEL_COMMON = 3;
    localparam int SEL_DPRAM  = 4;
    localparam int SEL_SEMA   = 5;
    localparam int SEL_PER1   = 6;
    localparam int SEL_PER2   = 7;

    // Region indices
    localparam int RG_LOW    = 0;
    localparam int RG_DPRAM  = 1;
    localparam int RG_SEMA   = 2;
    localparam int RG_PER1   = 3;
    localparam int RG_PER2   = 4;
    localparam int RG_BANK0  = 5;
    localparam int RG_BANK1  = 6;
    localparam int RG_COMMON = 7;
    localparam int NUM_RG    = 8;

    // Lower bound of a region
    function automatic logic [ADDR_W-1:0] rg_lo(input int idx);
        case (idx)
            RG_LOW:    return 16'h0000;
            RG_DPRAM:  return 16'hE000;
            RG_SEMA:   return 16'hF000;
            RG_PER1:   return 16'hF400;
            RG_PER2:   return 16'hF800;
            RG_BANK0:  return 16'hFC00;
            RG_BANK1:  return 16'hFD00;
            default:   return 16'hFF00;
        endcase
    endfunction

    // Upper bound of a region (inclusive)
    function automatic logic [ADDR_W-1:0] rg_hi(input int idx);
        case (idx)
            RG_LOW:    return 16'hDFFF;
            RG_DPRAM:  return 16'hEFFF;
            RG_SEMA:   return 16'hF3FF;
            RG_PER1:   return 16'hF7FF;
            RG_PER2:   return 16'hFBFF;
            RG_BANK0:  return 16'hFCFF;
            RG_BANK1:  return 16'hFDFF;
            default:   return 16'hFFFF;
        endcase
    endfunction

endpackage

// File: rtl/xmd_range.sv
// Single address-range comparator. Flags addr inside [LO, HI].
// Assumes LO <= HI. Bounds at the ends of the address space drop the
// redundant comparison, so each instance builds only what it needs.
module xmd_range #(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] LO = '0,
    parameter logic [ADDR_W-1:0] HI = '1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);

    localparam bool_lo_zero = (LO == '0);
    localparam bool_hi_top  = (HI == '1);

    generate
        if (bool_lo_zero && bool_hi_top) begin : g_all
            // Whole space: always inside
            assign hit = 1'b1;
        end else if (bool_lo_zero) begin : g_upper_only
            // Only the upper bound matters
            assign hit = (addr <= HI);
        end else if (bool_hi_top) begin : g_lower_only
            // Only the lower bound matters
            assign hit = (addr >= LO);
        end else begin : g_both
            // Both bounds matter
            assign hit = (addr >= LO) && (addr <= HI);
        end
    endgenerate

endmodule

// File: rtl/xmd_region_map.sv
// Classifies the bus address into the fixed regions of the memory map.
// Assumes the regions in the package do not overlap.
module xmd_region_map
    import xmd_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output logic [NUM_RG-1:0] rg_hit
);

    genvar g;
    generate
        for (g = 0; g < NUM_RG; g++) begin : g_rg
            xmd_range #(
                .ADDR_W (ADDR_W),
                .LO     (rg_lo(g)),
                .HI     (rg_hi(g))
            ) u_range (
                .addr (addr),
                .hit  (rg_hit[g])
            );
        end
    endgenerate

endmodule

// File: rtl/xmd_code_dec.sv
// Code-fetch decode: picks the code target from the mode.
// Assumes the caller gates the result with the code-fetch strobe.
module xmd_code_dec
    import xmd_pkg::*;
(
    input  mem_mode_e          mode,
    input  logic               hit_low,
    input  logic               hit_common,
    output logic [NUM_SEL-1:0] code_sel
);

    // Choose flash, code RAM, shared RAM or nothing for a fetch
    always_comb begin
        code_sel = '0;
        if (hit_common) begin
            code_sel[SEL_COMMON] = 1'b1;
        end else begin
            case (mode)
                MODE_LOADER, MODE_APP: code_sel[SEL_FLASH] = 1'b1;
                MODE_HARVARD:          code_sel[SEL_CRAM]  = 1'b1;
                default:               code_sel[SEL_DRAM]  = hit_low;
            endcase
        end
    end

endmodule

// File: rtl/xmd_data_dec.sv
// Data-space decode for read and write strobes. I/O regions are data-only
// in every mode; peripherals are hidden in loader mode.
// Assumes the caller gates the result with a data strobe.
module xmd_data_dec
    import xmd_pkg::*;
(
    input  mem_mode_e          mode,
    input  logic               hit_low,
    input  logic               hit_dpram,
    input  logic               hit_sema,
    input  logic               hit_per1,
    input  logic               hit_per2,
    input  logic               hit_common,
    output logic [NUM_SEL-1:0] data_sel
);

    logic per_en;

    // Peripherals are reachable in every mode except loader
    assign per_en = (mode != MODE_LOADER);

    // Map the data region onto its select line
    always_comb begin
        data_sel = '0;
        data_sel[SEL_COMMON] = hit_common;
        data_sel[SEL_DRAM]   = hit_low;
        data_sel[SEL_DPRAM]  = hit_dpram;
        data_sel[SEL_SEMA]   = hit_sema;
        data_sel[SEL_PER1]   = hit_per1 && per_en;
        data_sel[SEL_PER2]   = hit_per2 && per_en;
    end

endmodule

// File: rtl/xmd_bank_reg.sv
// Data-RAM bank latch. Application-mode writes into one of the two trigger
// windows set the bank; everything else holds it.
// Assumes the strobe and address are stable at the rising edge.
module xmd_bank_reg
    import xmd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  mem_mode_e mode,
    input  logic      wr_strobe,
    input  logic      hit_bank0,
    input  logic      hit_bank1,
    output logic      bank
);

    logic wr_app;

    // A write counts only in application mode
    assign wr_app = wr_strobe && (mode == MODE_APP);

    // Latch the bank on a qualifying write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank <= 1'b0;
        end else if (wr_app && hit_bank1) begin
            bank <= 1'b1;
        end else if (wr_app && hit_bank0) begin
            bank <= 1'b0;
        end
    end

    // R8: the bank holds across any cycle without a write strobe
    p_bank_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_strobe |=> $stable(bank));

    // R8: a rise of the bank follows an application write to the upper window
    p_bank_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bank) |-> $past(wr_strobe && mode == MODE_APP && hit_bank1));

endmodule

// File: rtl/xmd_decoder.sv
// Top of the memory-mode decoder. Classifies the address, decodes the
// code and data paths separately, applies the strobes and holds the bank.
// Assumes at most the code strobe or the data strobes are meant per cycle;
// the code strobe wins if both are raised.
module xmd_decoder
    import xmd_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               code_fetch,
    input  logic               rd_strobe,
    input  logic               wr_strobe,
    input  logic [1:0]         mode,
    output logic [NUM_SEL-1:0] sel,
    output logic               ram_bank,
    output logic [SEMA_W-1:0]  sema_idx
);

    mem_mode_e          mode_e;
    logic [NUM_RG-1:0]  rg_hit;
    logic [NUM_SEL-1:0] code_sel;
    logic [NUM_SEL-1:0] data_sel;
    logic               data_acc;

    assign mode_e   = mem_mode_e'(mode);
    assign data_acc = rd_strobe || wr_strobe;

    xmd_region_map u_map (
        .addr   (addr),
        .rg_hit (rg_hit)
    );

    xmd_code_dec u_code (
        .mode       (mode_e),
        .hit_low    (rg_hit[RG_LOW]),
        .hit_common (rg_hit[RG_COMMON]),
        .code_sel   (code_sel)
    );

    xmd_data_dec u_data (
        .mode       (mode_e),
        .hit_low    (rg_hit[RG_LOW]),
        .hit_dpram  (rg_hit[RG_DPRAM]),
        .hit_sema   (rg_hit[RG_SEMA]),
        .hit_per1   (rg_hit[RG_PER1]),
        .hit_per2   (rg_hit[RG_PER2]),
        .hit_common (rg_hit[RG_COMMON]),
        .data_sel   (data_sel)
    );

    xmd_bank_reg u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode_e),
        .wr_strobe (wr_strobe && !code_fetch),
        .hit_bank0 (rg_hit[RG_BANK0]),
        .hit_bank1 (rg_hit[RG_BANK1]),
        .bank      (ram_bank)
    );

    // Apply strobes with code-fetch priority
    always_comb begin
        if (code_fetch)    sel = code_sel;
        else if (data_acc) sel = data_sel;
        else               sel = '0;
    end

    // Semaphore number from the low address bits while selected
    assign sema_idx = sel[SEL_SEMA] ? addr[SEMA_W-1:0] : '0;

    // R9: never more than one select
    p_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));

    // R9: idle bus selects nothing
    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(code_fetch || rd_strobe || wr_strobe) |-> (sel == '0));

    // R1: top window always reaches the common RAM
    p_common_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((code_fetch || rd_strobe || wr_strobe) && addr >= 16'hFF00)
            |-> sel[SEL_COMMON]);

    // R2: peripherals stay dark in loader mode
    p_no_per_loader_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0) |-> !(sel[SEL_PER1] || sel[SEL_PER2]));

    // R3: code fetches never reach the data-only I/O regions
    p_io_data_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        code_fetch |-> !(sel[SEL_DPRAM] || sel[SEL_SEMA]
                         || sel[SEL_PER1] || sel[SEL_PER2]));

endmodule

// File: tb/xmd_decoder_bench.sv
module xmd_decoder_bench;

    localparam logic [7:0] S_NONE  = 8'h00;
    localparam logic [7:0] S_FLASH = 8'h01;
    localparam logic [7:0] S_DRAM  = 8'h02;
    localparam logic [7:0] S_CRAM  = 8'h04;
    localparam logic [7:0] S_COMM  = 8'h08;
    localparam logic [7:0] S_DPRAM = 8'h10;
    localparam logic [7:0] S_SEMA  = 8'h20;
    localparam logic [7:0] S_PER1  = 8'h40;
    localparam logic [7:0] S_PER2  = 8'h80;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic        code_fetch = 1'b0;
    logic        rd_strobe = 1'b0;
    logic        wr_strobe = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [7:0]  sel;
    logic        ram_bank;
    logic [2:0]  sema_idx;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    xmd_decoder u_xmd_decoder (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (addr),
        .code_fetch (code_fetch),
        .rd_strobe  (rd_strobe),
        .wr_strobe  (wr_strobe),
        .mode       (mode),
        .sel        (sel),
        .ram_bank   (ram_bank),
        .sema_idx   (sema_idx)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    // Drive one access at the falling edge and sample before the rising edge
    task automatic acc(input logic [1:0] m, input logic [15:0] a,
                       input logic cf, input logic rd, input logic wr);
        @(negedge clk);
        mode = m; addr = a; code_fetch = cf; rd_strobe = rd; wr_strobe = wr;
        #1;
    endtask

    task automatic idle_bus();
        @(negedge clk);
        code_fetch = 1'b0; rd_strobe = 1'b0; wr_strobe = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        check("R8 reset bank", {7'd0, ram_bank}, 8'd0);
        check("R9 idle", sel, S_NONE);
    endtask

    task automatic t_common();
        for (int m = 0; m < 4; m++) begin
            acc(2'(m), 16'hFF00, 1, 0, 0); check("R1 code", sel, S_COMM);
            acc(2'(m), 16'hFFFF, 0, 1, 0); check("R1 read", sel, S_COMM);
            acc(2'(m), 16'hFF80, 0, 0, 1); check("R1 write", sel, S_COMM);
        end
        idle_bus();
    endtask

    task automatic t_io();
        for (int m = 0; m < 4; m++) begin
            acc(2'(m), 16'hE000, 0, 1, 0); check("R3 dpram lo", sel, S_DPRAM);
            acc(2'(m), 16'hEFFF, 0, 0, 1); check("R3 dpram hi", sel, S_DPRAM);
            acc(2'(m), 16'hF3FD, 0, 1, 0); check("R3 sema", sel, S_SEMA);
            check("R3 sema idx", {5'd0, sema_idx}, 8'd5);
            acc(2'(m), 16'hF400, 0, 1, 0);
            check("R2 per1", sel, (m == 0) ? S_NONE : S_PER1);
            acc(2'(m), 16'hFBFF, 0, 0, 1);
            check("R2 per2", sel, (m == 0) ? S_NONE : S_PER2);
            acc(2'(m), 16'hF7FF, 1, 0, 0);
            check("R9 code at per1", sel, (m == 3) ? S_NONE : (m == 2 ? S_CRAM : S_FLASH));
        end
        acc(2'd1, 16'hE003, 0, 1, 0);
        check("R3 idx zero off sema", {5'd0, sema_idx}, 8'd0);
        idle_bus();
    endtask

    task automatic t_loader_app();
        for (int m = 0; m < 2; m++) begin
            acc(2'(m), 16'h0000, 1, 0, 0); check("R4 flash low", sel, S_FLASH);
            acc(2'(m), 16'hFEFF, 1, 0, 0); check("R4 flash top", sel, S_FLASH);
            acc(2'(m), 16'h1234, 0, 1, 0); check("R7 data ram", sel, S_DRAM);
            acc(2'(m), 16'hDFFF, 0, 0, 1); check("R7 data edge", sel, S_DRAM);
        end
        idle_bus();
    endtask

    task automatic t_harvard();
        acc(2'd2, 16'h0100, 1, 0, 0); check("R5 code ram", sel, S_CRAM);
        acc(2'd2, 16'hFEFF, 1, 0, 0); check("R5 code ram top", sel, S_CRAM);
        acc(2'd2, 16'h0100, 0, 1, 0); check("R5 data ram", sel, S_DRAM);
        acc(2'd2, 16'hDFFF, 0, 0, 1); check("R5 data edge", sel, S_DRAM);
        idle_bus();
    endtask

    task automatic t_vonn();
        acc(2'd3, 16'h0200, 1, 0, 0); check("R6 code shared", sel, S_DRAM);
        acc(2'd3, 16'hDFFF, 1, 0, 0); check("R6 code edge", sel, S_DRAM);
        acc(2'd3, 16'h0200, 0, 1, 0); check("R6 data shared", sel, S_DRAM);
        acc(2'd3, 16'hE000, 1, 0, 0); check("R6 code unmapped", sel, S_NONE);
        acc(2'd3, 16'hFE00, 1, 0, 0); check("R6 code gap", sel, S_NONE);
        idle_bus();
    endtask

    task automatic t_unmapped_priority();
        acc(2'd2, 16'hFE10, 0, 1, 0); check("R9 data gap", sel, S_NONE);
        acc(2'd1, 16'hFC00, 0, 1, 0); check("R9 bank window read", sel, S_NONE);
        acc(2'd2, 16'h0010, 1, 1, 0); check("R9 code priority", sel, S_CRAM);
        acc(2'd1, 16'hF000, 1, 0, 1); check("R9 code priority io", sel, S_FLASH);
        acc(2'd1, 16'h0010, 0, 0, 0); check("R9 no strobe", sel, S_NONE);
        acc(2'd0, 16'hE800, 0, 1, 1); check("R10 both data strobes", sel, S_DPRAM);
        addr = 16'hF001; #0.5;
        check("R10 comb follow", sel, S_SEMA);
        idle_bus();
    endtask

    task automatic t_bank();
        acc(2'd1, 16'hFD40, 0, 0, 1);
        check("R9 bank write no sel", sel, S_NONE);
        check("R8 before edge", {7'd0, ram_bank}, 8'd0);
        idle_bus();
        check("R8 set bank1", {7'd0, ram_bank}, 8'd1);
        acc(2'd2, 16'hFC00, 0, 0, 1); idle_bus();
        check("R8 harvard ignored", {7'd0, ram_bank}, 8'd1);
        acc(2'd0, 16'hFC80, 0, 0, 1); idle_bus();
        check("R8 loader ignored", {7'd0, ram_bank}, 8'd1);
        acc(2'd1, 16'hFC10, 0, 1, 0); idle_bus();
        check("R8 read ignored", {7'd0, ram_bank}, 8'd1);
        acc(2'd1, 16'hFE00, 0, 0, 1); idle_bus();
        check("R8 outside window", {7'd0, ram_bank}, 8'd1);
        acc(2'd1, 16'hFCFF, 0, 0, 1); idle_bus();
        check("R8 set bank0", {7'd0, ram_bank}, 8'd0);
        acc(2'd3, 16'hFD00, 0, 0, 1); idle_bus();
        check("R8 vonn ignored", {7'd0, ram_bank}, 8'd0);
        acc(2'd1, 16'hFDFF, 0, 0, 1); idle_bus();
        check("R8 set bank1 edge", {7'd0, ram_bank}, 8'd1);
        @(negedge clk); rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; #1;
        check("R8 reset clears", {7'd0, ram_bank}, 8'd0);
    endtask

    initial begin
        t_reset();
        t_common();
        t_io();
        t_loader_app();
        t_harvard();
        t_vonn();
        t_unmapped_priority();
        t_bank();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule